// File: doc/BRIEF.md
# Configurable Asynchronous Serial Transmitter

This block turns one parallel character into an asynchronous frame on a single serial line. A character is offered on a valid/ready handshake together with its frame settings. The block then drives one low start bit, the data bits least significant first, an optional parity bit, and a high stop interval. Every bit interval is measured in pulses of an external tick input that runs at sixteen times the bit rate. The block has no divider of its own, and the `tick` input is the only time base.

Word length can be 5 to 8 bits. Parity can be even, odd or absent. The stop interval can be 0, 1, 1.5, 2, 2.5 or 3 bit times. Stop time is counted in half-bit steps of eight ticks, so the fractional lengths are exact. A break control holds the line low while it is asserted. A character offered during a break waits until the break is released. A break raised during a frame takes effect only after that frame is complete.

The sequencer has six states:
- `ST_IDLE`: line high, waiting.
- `ST_START`: start bit.
- `ST_DATA`: data bits.
- `ST_PARITY`: parity bit.
- `ST_STOP`: stop interval, walked in half-bit steps.
- `ST_BREAK`: line held low.

Its transitions are:
- IDLE→BREAK when break is asserted.
- IDLE→START on an accepted character.
- START→DATA after one bit time.
- DATA→DATA after each data bit except the last.
- DATA→PARITY after the last data bit when parity is on.
- DATA→STOP or PARITY→STOP when the stop length is not zero.
- DATA→IDLE or PARITY→IDLE when the stop length is zero.
- STOP→STOP after each half step except the last.
- STOP→IDLE after the last half step.
- BREAK→IDLE when break is released.

Top module: `async_tx_engine`

## Requirements
- R1: After reset, `txd` is 1, `busy` is 0 and `in_ready` is 1.
- R2: Acceptance and captured settings:
  - `in_ready` is 1 only in the idle state while `brk` is 0.
  - A character is accepted on a clock edge where `in_valid` and `in_ready` are both 1.
  - The data and all settings are captured at that edge.
  - Changes to `in_data`, `cfg_len`, `cfg_par` or `cfg_stop` after that edge do not alter the frame.
- R3: Start and data bits:
  - From the cycle after acceptance, `txd` is 0 for 16 ticks (the start bit).
  - The data bits follow, least significant first, each 16 ticks long.
  - `cfg_len` values 0, 1, 2 and 3 select 5, 6, 7 and 8 data bits.
  - Unused upper bits of `in_data` are never sent.
- R4: Parity:
  - `cfg_par` 1 selects even parity, which makes the count of ones over the data bits and the parity bit even.
  - `cfg_par` 2 selects odd parity, which makes that count odd.
  - `cfg_par` 0 and 3 send no parity bit.
  - When present, the parity bit lasts 16 ticks and follows the last data bit.
- R5: Stop interval:
  - After the last data or parity bit, `txd` is 1 for a stop interval.
  - `cfg_stop` codes 0, 1, 2, 3, 4 and 5 give intervals of 0, 16, 24, 32, 40 and 48 ticks.
  - Codes 6 and 7 give 16 ticks.
- R6: Frame status:
  - `busy` is 1 from the cycle after acceptance until the clock edge that consumes the last tick of the frame.
  - It falls only on a tick.
  - In the cycle after it falls, `in_ready` is 1 again.
- R7: Tick pacing:
  - While a frame is in progress, `txd` changes only on a clock edge whose cycle carried a tick.
  - Ticks during idle are not counted, so every start bit lasts a full 16 ticks.
- R8: Break while idle:
  - `brk` asserted while idle drives `txd` to 0 from the next cycle and holds it there as long as `brk` stays 1.
  - During the break, `in_ready` and `busy` stay 0, and an offered character is not accepted.
  - After `brk` is released, the line returns high and the waiting character is then sent.
- R9: A break asserted during a frame does not disturb that frame. The break starts one cycle after `busy` falls.
- R10: Whenever the block is idle and no break is in force, `txd` is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| tick | input | 1 | One-cycle pulse at 16 times the bit rate |
| in_valid | input | 1 | A character is offered |
| in_ready | output | 1 | The block can accept a character this cycle |
| in_data | input | DATA_W | Character to send, low bits used |
| cfg_len | input | 2 | Word length code: 0 to 3 selects 5 to 8 bits |
| cfg_par | input | 2 | Parity code: 0 none, 1 even, 2 odd, 3 none |
| cfg_stop | input | 3 | Stop code: 0, 1, 1.5, 2, 2.5, 3 bits for 0 to 5; 6 and 7 give 1 bit |
| brk | input | 1 | Hold the line low while idle |
| txd | output | 1 | Serial output, idle high |
| busy | output | 1 | A frame is in progress |

## Verification
The main check uses a table of characters. Each row combines one word length, one parity code and one stop code, and every stop code including the two spare ones appears at least once. The bench records the line once per tick and compares the whole frame with the expected bits. This exposes a wrong bit order, a wrong bit count, a wrong parity sense and a stop interval that is off by one half step. Data patterns of all ones, all zeros and alternating bits make parity and masking errors show up as wrong bits. Between every acceptance and the first tick, the settings are scrambled, which separates values captured at acceptance from values read live. Directed cases cover break while idle with a character waiting, and break raised in the middle of a frame.

// File: rtl/atx_pkg.sv
package atx_pkg;

    typedef enum logic [2:0] {
        ST_IDLE   = 3'd0,
        ST_START  = 3'd1,
        ST_DATA   = 3'd2,
        ST_PARITY = 3'd3,
        ST_STOP   = 3'd4,
        ST_BREAK  = 3'd5
    } tx_state_e;

    typedef enum logic [1:0] {
        PAR_NONE     = 2'd0,
        PAR_EVEN     = 2'd1,
        PAR_ODD      = 2'd2,
        PAR_NONE_ALT = 2'd3
    } parity_e;

    localparam int STOP_CODE_W = 3;
    localparam int HALF_CNT_W  = 3;

endpackage

// File: rtl/atx_tick_timer.sv
module atx_tick_timer #(
    parameter int TICKS_PER_BIT = 16
) (
    input  logic clk,
    input  logic rst_n,
    input  logic tick,
    input  logic clear,
    input  logic half_sel,
    output logic done
);
    localparam int CW = $clog2(TICKS_PER_BIT + 1);
    localparam logic [CW-1:0] FULL_LIM = CW'(TICKS_PER_BIT);
    localparam logic [CW-1:0] HALF_LIM = CW'(TICKS_PER_BIT / 2);

    logic [CW-1:0] cnt_q;
    logic [CW-1:0] limit;

    always_comb begin
        limit = half_sel ? HALF_LIM : FULL_LIM;
        done  = tick && (cnt_q == limit - CW'(1));
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (clear) begin
            cnt_q <= '0;
        end else if (tick) begin
            if (done) cnt_q <= '0;
            else      cnt_q <= cnt_q + CW'(1);
        end
    end
endmodule

// File: rtl/atx_shifter.sv
module atx_shifter
    import atx_pkg::*;
#(
    parameter int DATA_W   = 8,
    parameter int WORD_MIN = 5
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load,
    input  logic              shift,
    input  logic [DATA_W-1:0] data,
    input  logic [1:0]        len_code,
    input  logic [1:0]        par_code,
    output logic              bit_out,
    output logic              par_bit,
    output logic              last_bit
);
    localparam int BLW = $clog2(DATA_W);

    logic [DATA_W-1:0] sh_q;
    logic [BLW-1:0]    left_q;
    logic [DATA_W-1:0] mask;
    logic [DATA_W-1:0] masked;
    int unsigned       nbits;

    assign nbits = WORD_MIN + int'(len_code);

    for (genvar i = 0; i < DATA_W; i++) begin : g_mask
        assign mask[i] = (i < nbits);
    end

    assign masked = data & mask;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sh_q    <= '0;
            left_q  <= '0;
            par_bit <= 1'b0;
        end else if (load) begin
            sh_q    <= masked;
            left_q  <= BLW'(nbits - 1);
            par_bit <= (^masked) ^ (parity_e'(par_code) == PAR_ODD);
        end else if (shift) begin
            sh_q    <= sh_q >> 1;
            left_q  <= left_q - BLW'(1);
        end
    end

    assign bit_out  = sh_q[0];
    assign last_bit = (left_q == '0);
endmodule

// File: rtl/atx_stop_plan.sv
module atx_stop_plan
    import atx_pkg::*;
(
    input  logic [STOP_CODE_W-1:0] stop_code,
    output logic [HALF_CNT_W-1:0]  halves
);
    always_comb begin
        unique case (stop_code)
            3'd0:    halves = 3'd0;
            3'd1:    halves = 3'd2;
            3'd2:    halves = 3'd3;
            3'd3:    halves = 3'd4;
            3'd4:    halves = 3'd5;
            3'd5:    halves = 3'd6;
            default: halves = 3'd2;
        endcase
    end
endmodule

// File: rtl/async_tx_engine.sv
module async_tx_engine
    import atx_pkg::*;
#(
    parameter int DATA_W        = 8,
    parameter int WORD_MIN      = 5,
    parameter int TICKS_PER_BIT = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              tick,
    input  logic              in_valid,
    output logic              in_ready,
    input  logic [DATA_W-1:0] in_data,
    input  logic [1:0]        cfg_len,
    input  logic [1:0]        cfg_par,
    input  logic [2:0]        cfg_stop,
    input  logic              brk,
    output logic              txd,
    output logic              busy
);
    tx_state_e st_q, st_d;

    logic                   accept;
    logic [1:0]             par_q;
    logic [STOP_CODE_W-1:0] stop_q;
    logic [HALF_CNT_W-1:0]  halves;
    logic [HALF_CNT_W-1:0]  half_cnt_q;
    logic                   bit_done;
    logic                   timer_clear;
    logic                   half_sel;
    logic                   data_bit;
    logic                   par_bit;
    logic                   last_bit;
    logic                   par_en;
    tx_state_e              after_body;

    assign accept = in_valid && in_ready;
    assign par_en = (parity_e'(par_q) == PAR_EVEN) || (parity_e'(par_q) == PAR_ODD);

    atx_tick_timer #(.TICKS_PER_BIT(TICKS_PER_BIT)) u_timer (
        .clk      (clk),
        .rst_n    (rst_n),
        .tick     (tick),
        .clear    (timer_clear),
        .half_sel (half_sel),
        .done     (bit_done)
    );

    atx_shifter #(.DATA_W(DATA_W), .WORD_MIN(WORD_MIN)) u_shift (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (accept),
        .shift    ((st_q == ST_DATA) && bit_done),
        .data     (in_data),
        .len_code (cfg_len),
        .par_code (cfg_par),
        .bit_out  (data_bit),
        .par_bit  (par_bit),
        .last_bit (last_bit)
    );

    atx_stop_plan u_stop (
        .stop_code (stop_q),
        .halves    (halves)
    );

    // captured frame settings
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            par_q  <= '0;
            stop_q <= '0;
        end else if (accept) begin
            par_q  <= cfg_par;
            stop_q <= cfg_stop;
        end
    end

    // half-bit step counter of the stop interval
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)              half_cnt_q <= '0;
        else if (st_q != ST_STOP) half_cnt_q <= '0;
        else if (bit_done)        half_cnt_q <= half_cnt_q + HALF_CNT_W'(1);
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= ST_IDLE;
        else        st_q <= st_d;
    end

    // next state
    always_comb begin
        after_body = (halves != '0) ? ST_STOP : ST_IDLE;
        st_d       = st_q;
        unique case (st_q)
            ST_IDLE: begin
                if (brk)         st_d = ST_BREAK;
                else if (accept) st_d = ST_START;
            end
            ST_BREAK: begin
                if (!brk) st_d = ST_IDLE;
            end
            ST_START: begin
                if (bit_done) st_d = ST_DATA;
            end
            ST_DATA: begin
                if (bit_done && last_bit) st_d = par_en ? ST_PARITY : after_body;
            end
            ST_PARITY: begin
                if (bit_done) st_d = after_body;
            end
            ST_STOP: begin
                if (bit_done && (half_cnt_q == halves - HALF_CNT_W'(1))) st_d = ST_IDLE;
            end
            default: st_d = ST_IDLE;
        endcase
    end

    assign timer_clear = (st_d != st_q) || (st_q == ST_IDLE) || (st_q == ST_BREAK);
    assign half_sel    = (st_q == ST_STOP);

    // outputs
    always_comb begin
        txd      = 1'b1;
        busy     = 1'b0;
        in_ready = 1'b0;
        unique case (st_q)
            ST_IDLE:   in_ready = !brk;
            ST_BREAK:  txd = 1'b0;
            ST_START:  begin txd = 1'b0;     busy = 1'b1; end
            ST_DATA:   begin txd = data_bit; busy = 1'b1; end
            ST_PARITY: begin txd = par_bit;  busy = 1'b1; end
            ST_STOP:   busy = 1'b1;
            default:   txd = 1'b1;
        endcase
    end
endmodule

// File: rtl/atx_tx_checker.sv
module atx_tx_checker (
    input logic clk,
    input logic rst_n,
    input logic tick,
    input logic in_valid,
    input logic in_ready,
    input logic brk,
    input logic txd,
    input logic busy
);
    AST_READY_ONLY_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        in_ready |-> (!busy && !brk)); // R2

    AST_ACCEPT_STARTS_LOW: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && in_ready) |=> (busy && !txd)); // R3

    AST_TXD_TICK_PACED: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && $past(busy) && !$past(tick)) |-> $stable(txd)); // R7

    AST_BUSY_FALLS_ON_TICK: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(busy) |-> $past(tick)); // R6

    AST_BREAK_HOLDS_LOW: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && $past(brk) && !$past(busy)) |-> (!txd && !busy)); // R8

    AST_IDLE_LINE_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && !busy && !brk && !$past(brk)) |-> txd); // R10
endmodule

bind async_tx_engine atx_tx_checker u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .tick     (tick),
    .in_valid (in_valid),
    .in_ready (in_ready),
    .brk      (brk),
    .txd      (txd),
    .busy     (busy)
);

// File: tb/tb_async_tx_engine.sv
`timescale 1ns/1ps
module tb_async_tx_engine;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       tick = 1'b0;
    logic       in_valid = 1'b0;
    logic       in_ready;
    logic [7:0] in_data = '0;
    logic [1:0] cfg_len = '0;
    logic [1:0] cfg_par = '0;
    logic [2:0] cfg_stop = '0;
    logic       brk = 1'b0;
    logic       txd;
    logic       busy;

    int checks = 0;
    int errors = 0;
    bit done_flag = 0;

    bit rec_en = 0;
    int nsamp = 0;
    bit samples [0:511];

    always #4 clk = ~clk;

    async_tx_engine dut (
        .clk(clk), .rst_n(rst_n), .tick(tick), .in_valid(in_valid), .in_ready(in_ready),
        .in_data(in_data), .cfg_len(cfg_len), .cfg_par(cfg_par), .cfg_stop(cfg_stop),
        .brk(brk), .txd(txd), .busy(busy)
    );

    // tick every second clock
    initial begin
        forever begin
            @(posedge clk);
            #1 tick = ~tick;
        end
    end

    // one sample per consumed tick while a frame runs
    always @(negedge clk) begin
        if (rec_en && busy && tick && nsamp < 512) begin
            samples[nsamp] = txd;
            nsamp = nsamp + 1;
        end
    end

    // vector: {data, len, par, stop}
    localparam int NV = 9;
    localparam logic [14:0] VECS [NV] = '{
        {8'hA5, 2'd3, 2'd0, 3'd1},
        {8'h3C, 2'd0, 2'd1, 3'd0},
        {8'hFF, 2'd1, 2'd2, 3'd2},
        {8'h00, 2'd2, 2'd1, 3'd3},
        {8'h5A, 2'd3, 2'd2, 3'd4},
        {8'h81, 2'd3, 2'd3, 3'd5},
        {8'hE7, 2'd0, 2'd2, 3'd6},
        {8'h96, 2'd2, 2'd0, 3'd7},
        {8'h01, 2'd1, 2'd1, 3'd2}
    };

    task automatic check(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    function automatic int stop_ticks(input logic [2:0] s);
        case (s)
            3'd0: return 0;
            3'd1: return 16;
            3'd2: return 24;
            3'd3: return 32;
            3'd4: return 40;
            3'd5: return 48;
            default: return 16;
        endcase
    endfunction

    function automatic int exp_len(input logic [14:0] v);
        int nb = 5 + int'(v[6:5]);
        int p  = (v[4:3] == 2'd1 || v[4:3] == 2'd2) ? 1 : 0;
        return 16 * (1 + nb + p) + stop_ticks(v[2:0]);
    endfunction

    function automatic bit exp_bit(input logic [14:0] v, input int t);
        int nb = 5 + int'(v[6:5]);
        bit pe = (v[4:3] == 2'd1 || v[4:3] == 2'd2);
        bit ones = 0;
        int b;
        for (int i = 0; i < nb; i++) ones ^= v[7 + i];
        if (t < 16) return 1'b0;
        b = (t - 16) / 16;
        if (b < nb) return v[7 + b];
        if (pe && b == nb) return ones ^ (v[4:3] == 2'd2);
        return 1'b1;
    endfunction

    // offer a character, wait for acceptance, scramble inputs afterwards
    task automatic send(input logic [14:0] v);
        @(posedge clk); #1;
        in_data  = v[14:7];
        cfg_len  = v[6:5];
        cfg_par  = v[4:3];
        cfg_stop = v[2:0];
        in_valid = 1'b1;
        do @(negedge clk); while (!in_ready);
        @(posedge clk); #1;
        in_valid = 1'b0;
        in_data  = ~v[14:7];
        cfg_len  = ~v[6:5];
        cfg_par  = ~v[4:3];
        cfg_stop = ~v[2:0];
    endtask

    task automatic wait_frame_end();
        while (!busy) @(negedge clk);
        while (busy)  @(negedge clk);
    endtask

    task automatic check_frame(input logic [14:0] v, input string req);
        int bad = -1;
        int el = exp_len(v);
        check(nsamp == el, {req, " frame length in ticks"}, nsamp, el);
        for (int t = 0; t < el && t < nsamp; t++)
            if (bad < 0 && samples[t] != exp_bit(v, t)) bad = t;
        if (bad < 0) check(1'b1, req, 0, 0);
        else check(1'b0, {req, " bit at tick index"}, int'(samples[bad]), int'(exp_bit(v, bad)));
    endtask

    initial begin
        repeat (4) @(posedge clk);
        @(negedge clk);
        // R1 reset state
        check(txd == 1'b1, "R1 txd in reset", txd, 1);
        check(busy == 1'b0, "R1 busy in reset", busy, 0);
        @(posedge clk); #1 rst_n = 1'b1;
        repeat (5) @(negedge clk);
        check(txd == 1'b1 && busy == 1'b0 && in_ready == 1'b1, "R1 idle after reset",
              {txd, busy, in_ready}, 3'b101);

        // vector walk: R2 R3 R4 R5 R6 R7 R10
        for (int k = 0; k < NV; k++) begin
            nsamp = 0;
            rec_en = 1;
            send(VECS[k]);
            wait_frame_end();
            rec_en = 0;
            check_frame(VECS[k], "R3 R4 R5 R2 frame");
            check(in_ready == 1'b1, "R6 ready after busy falls", in_ready, 1);
            check(txd == 1'b1, "R10 idle line high", txd, 1);
            repeat (3) @(negedge clk);
        end

        // R8 break while idle with a waiting character
        @(posedge clk); #1 brk = 1'b1;
        @(posedge clk);
        @(negedge clk);
        check(txd == 1'b0, "R8 break drives low", txd, 0);
        check(in_ready == 1'b0, "R8 ready low in break", in_ready, 0);
        @(posedge clk); #1;
        in_data = 8'h6B; cfg_len = 2'd3; cfg_par = 2'd1; cfg_stop = 3'd2; in_valid = 1'b1;
        nsamp = 0; rec_en = 1;
        repeat (60) @(negedge clk);
        check(busy == 1'b0 && txd == 1'b0, "R8 character held during break", {busy, txd}, 2'b00);
        check(nsamp == 0, "R8 no frame during break", nsamp, 0);
        @(posedge clk); #1 brk = 1'b0;
        @(posedge clk);
        @(negedge clk);
        check(txd == 1'b1 && in_ready == 1'b1, "R8 release returns idle", {txd, in_ready}, 2'b11);
        @(posedge clk); #1 in_valid = 1'b0;
        wait_frame_end();
        rec_en = 0;
        check_frame({8'h6B, 2'd3, 2'd1, 3'd2}, "R8 waiting character sent");

        // R9 break asserted mid-frame
        repeat (3) @(negedge clk);
        nsamp = 0; rec_en = 1;
        send({8'hC3, 2'd2, 2'd2, 3'd4});
        repeat (40) @(posedge clk);
        #1 brk = 1'b1;
        wait_frame_end();
        rec_en = 0;
        check_frame({8'hC3, 2'd2, 2'd2, 3'd4}, "R9 frame intact under break");
        @(negedge clk);
        check(txd == 1'b0, "R9 break after frame", txd, 0);
        @(posedge clk); #1 brk = 1'b0;
        repeat (3) @(negedge clk);
        check(txd == 1'b1, "R10 high after break", txd, 1);

        if (!done_flag) begin
            done_flag = 1;
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        #(8 * 150000);
        if (!done_flag) begin
            done_flag = 1;
            checks++;
            errors++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end
endmodule